// File: doc/BRIEF.md
# Bit-Sliced Ripple-Carry ALU

This block is an N-bit arithmetic and logic unit made of identical one-bit cells joined by a ripple carry. No result multiplexer sits at the end of the chain. Each cell has one small gate network, and a few shared control lines change its shape. One line flips the first stage from an exclusive-or to an and. One line cuts the carry out of the sum. One line switches the whole sum path off. One line opens an OR path, and one lets a cell copy the operand bit from its upper neighbour so the block can shift.

A three-bit function code drives a small decoder, which produces the shared control lines and the carry fed into the lowest cell. The block is purely combinational. The result and carry-out follow the operands and the function code after the gate and ripple delay, with no clock in the path.

Top module: `alu_ripple`

## Requirements
- R1: With function code 000 (add), {carry_out, result} equals opnd_a + opnd_b + carry_in as a WIDTH+1-bit sum.
- R2: With function code 001 (subtract), result equals opnd_a - opnd_b modulo 2^WIDTH, and carry_out is 1 exactly when opnd_a >= opnd_b (unsigned). carry_in has no effect.
- R3: With function code 010, result is opnd_a XOR opnd_b and carry_out is 0.
- R4: With function code 011, result is opnd_a AND opnd_b and carry_out is 0.
- R5: With function code 100, result is opnd_a OR opnd_b and carry_out is 0.
- R6: With function code 101 (arithmetic shift right by one), result bit WIDTH-1 equals opnd_a bit WIDTH-1, result bit i equals opnd_a bit i+1 for i below WIDTH-1, and carry_out equals opnd_a bit 0.
- R7: Function codes 110 and 111 give a result of all zeros and a carry_out of 0.
- R8: carry_in changes neither output for any function code other than 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | Primary operand; this is the value shifted by the shift operation |
| opnd_b | input | WIDTH | Secondary operand |
| carry_in | input | 1 | Carry into the lowest cell; used by add only |
| func_sel | input | 3 | Function code |
| result | output | WIDTH | Result word |
| carry_out | output | 1 | Carry from the top cell, or the bit shifted out |

## Verification
The bench sweeps every operand pair, both carry_in values and all eight function codes on a four-bit instance. Each output is compared with a value computed arithmetically in the bench. The block holds no state, so any fault in a cell's control decoding or in its gating shows up on the very next evaluation. A broken carry link shows up as a wrong result bit above the fault, or as a wrong carry_out, for some add or subtract pair. A misrouted neighbour link shows up as a wrong shifted bit, or a wrong sign bit, for some shift operand.

// File: rtl/alu_ripple_pkg.sv
package alu_ripple_pkg;
  localparam int FUNC_W = 3;

  typedef enum logic [FUNC_W-1:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_XOR = 3'd2,
    FN_AND = 3'd3,
    FN_OR  = 3'd4,
    FN_ASR = 3'd5,
    FN_Z6  = 3'd6,
    FN_Z7  = 3'd7
  } func_e;

  // Shared control lines fanned out to every cell.
  typedef struct packed {
    logic b_flip;    // invert operand b
    logic no_carry;  // carry excluded from result and chain
    logic and_sel;   // first stage performs nand instead of xnor
    logic sum_off;   // sum/xor/and path forced low
    logic or_off;    // nor-based or path forced low
    logic shift_en;  // take the neighbour's a bit
  } cell_ctl_t;
endpackage

// File: rtl/alu_ripple_dec.sv
module alu_ripple_dec
  import alu_ripple_pkg::*;
(
  input  logic [FUNC_W-1:0] func_sel,
  input  logic              carry_in,
  output cell_ctl_t         ctl,
  output logic              cin0
);
  always_comb begin
    ctl = '{b_flip: 1'b0, no_carry: 1'b1, and_sel: 1'b0,
            sum_off: 1'b1, or_off: 1'b1, shift_en: 1'b0};
    cin0 = 1'b0;
    unique case (func_e'(func_sel))
      FN_ADD: begin
        ctl.no_carry = 1'b0;
        ctl.sum_off  = 1'b0;
        cin0         = carry_in;
      end
      FN_SUB: begin
        ctl.no_carry = 1'b0;
        ctl.sum_off  = 1'b0;
        ctl.b_flip   = 1'b1;
        cin0         = 1'b1;
      end
      FN_XOR: ctl.sum_off = 1'b0;
      FN_AND: begin
        ctl.sum_off = 1'b0;
        ctl.and_sel = 1'b1;
      end
      FN_OR:  ctl.or_off   = 1'b0;
      FN_ASR: ctl.shift_en = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_ripple_cell.sv
module alu_ripple_cell
  import alu_ripple_pkg::*;
(
  input  logic      a,
  input  logic      b,
  input  logic      a_up,
  input  logic      cin,
  input  cell_ctl_t ctl,
  output logic      r,
  output logic      cout
);
  logic bx;
  logic stage1_n;
  logic half;
  logic sum_path;
  logic or_path;
  logic sh_path;
  logic carry_raw;

  always_comb begin
    bx        = b ^ ctl.b_flip;
    // first stage: xnor, or nand when and_sel is high
    stage1_n  = ctl.and_sel ? ~(a & bx) : ~(a ^ bx);
    half      = ~stage1_n;
    carry_raw = (a & bx) | (cin & (a ^ bx));
    cout      = ctl.no_carry ? 1'b0 : carry_raw;
    sum_path  = ctl.sum_off ? 1'b0 : (ctl.no_carry ? half : (half ^ cin));
    or_path   = ctl.or_off ? 1'b0 : ~(~(a | b));
    sh_path   = ctl.shift_en ? a_up : 1'b0;
    r         = sum_path | or_path | sh_path;
  end
endmodule

// File: rtl/alu_ripple.sv
module alu_ripple
  import alu_ripple_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]  opnd_a,
  input  logic [WIDTH-1:0]  opnd_b,
  input  logic              carry_in,
  input  logic [FUNC_W-1:0] func_sel,
  output logic [WIDTH-1:0]  result,
  output logic              carry_out
);
  localparam int TOP = WIDTH - 1;

  cell_ctl_t      ctl;
  logic           cin0;
  logic [WIDTH:0] chain;
  logic [WIDTH-1:0] upper;

  alu_ripple_dec u_dec (
    .func_sel (func_sel),
    .carry_in (carry_in),
    .ctl      (ctl),
    .cin0     (cin0)
  );

  assign chain[0] = cin0;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      if (i == TOP) begin : g_msb
        assign upper[i] = opnd_a[i];  // sign is kept
      end else begin : g_mid
        assign upper[i] = opnd_a[i+1];
      end
      alu_ripple_cell u_cell (
        .a    (opnd_a[i]),
        .b    (opnd_b[i]),
        .a_up (upper[i]),
        .cin  (chain[i]),
        .ctl  (ctl),
        .r    (result[i]),
        .cout (chain[i+1])
      );
    end
  endgenerate

  assign carry_out = chain[WIDTH] | (ctl.shift_en & opnd_a[0]);
endmodule

// File: rtl/alu_ripple_chk.sv
module alu_ripple_chk
  import alu_ripple_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0]  opnd_a,
  input logic [WIDTH-1:0]  opnd_b,
  input logic              carry_in,
  input logic [FUNC_W-1:0] func_sel,
  input logic [WIDTH-1:0]  result,
  input logic              carry_out
);
  logic [WIDTH:0] add_ref;
  logic [WIDTH:0] sub_ref;

  always_comb begin
    add_ref = {1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, carry_in};
    sub_ref = {1'b0, opnd_a} - {1'b0, opnd_b};
    if (func_sel == 3'd0)
      AST_ADD_SUM: assert ({carry_out, result} == add_ref); // R1
    if (func_sel == 3'd1)
      AST_SUB_DIFF: assert (result == sub_ref[WIDTH-1:0] && carry_out == (opnd_a >= opnd_b)); // R2
    if (func_sel == 3'd2)
      AST_XOR_RES: assert (result == (opnd_a ^ opnd_b) && !carry_out); // R3
    if (func_sel == 3'd3)
      AST_AND_RES: assert (result == (opnd_a & opnd_b) && !carry_out); // R4
    if (func_sel == 3'd4)
      AST_OR_RES: assert (result == (opnd_a | opnd_b) && !carry_out); // R5
    if (func_sel == 3'd5)
      AST_ASR_RES: assert (result == {opnd_a[WIDTH-1], opnd_a[WIDTH-1:1]} && carry_out == opnd_a[0]); // R6
    if (func_sel[2:1] == 2'b11)
      AST_ZERO_RES: assert (result == '0 && !carry_out); // R7
  end
endmodule

bind alu_ripple alu_ripple_chk #(.WIDTH(WIDTH)) u_chk (
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .carry_in  (carry_in),
  .func_sel  (func_sel),
  .result    (result),
  .carry_out (carry_out)
);

// File: tb/alu_ripple_test.sv
module alu_ripple_test;
  localparam int W = 4;
  localparam int WATCH = 100000;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a, b;
  logic         ci;
  logic [2:0]   fs;
  logic [W-1:0] res;
  logic         co;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  alu_ripple #(.WIDTH(W)) uut (
    .opnd_a(a), .opnd_b(b), .carry_in(ci), .func_sel(fs),
    .result(res), .carry_out(co)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCH && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCH);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic expect_out(input string tag, input logic [W-1:0] er, input logic ec);
    checks++;
    if (res !== er || co !== ec) begin
      errors++;
      $display("FAIL %s: fs=%0d a=%h b=%h ci=%0d actual r=%h co=%0d expected r=%h co=%0d",
               tag, fs, a, b, ci, res, co, er, ec);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    a = '0; b = '0; ci = 1'b0; fs = 3'd0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 idle", '0, 1'b0);

    for (int f = 0; f < 8; f++) begin
      for (int x = 0; x < (1 << W); x++) begin
        for (int y = 0; y < (1 << W); y++) begin
          for (int c = 0; c < 2; c++) begin
            logic [W:0]   wide;
            logic [W-1:0] er;
            logic         ec;
            string        tag;
            @(posedge clk);
            a = x[W-1:0]; b = y[W-1:0]; ci = c[0]; fs = f[2:0];
            @(negedge clk);
            case (f)
              0: begin wide = (W+1)'(x + y + c); er = wide[W-1:0]; ec = wide[W]; tag = "R1"; end
              1: begin er = W'(x - y); ec = (x >= y); tag = "R2/R8"; end
              2: begin er = W'(x ^ y); ec = 1'b0; tag = "R3/R8"; end
              3: begin er = W'(x & y); ec = 1'b0; tag = "R4/R8"; end
              4: begin er = W'(x | y); ec = 1'b0; tag = "R5/R8"; end
              5: begin er = W'((x >> 1) | (x & (1 << (W-1)))); ec = x[0]; tag = "R6/R8"; end
              default: begin er = '0; ec = 1'b0; tag = "R7/R8"; end
            endcase
            expect_out(tag, er, ec);
          end
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule